// File: doc/BRIEF.md
# Input Change Interrupt Controller

This block watches an 8-bit general-purpose port and requests attention from a host whenever a pin set up as an input changes level. It holds a snapshot of the synchronized pin levels. It compares the live levels against that snapshot under a per-pin direction mask. While any input-mode pin differs from its snapshot bit, the block drives an active-low, open-drain-style interrupt request.

The request clears in three ways. The first needs no action: the pins return to their snapshot values. The other two come from the bus slave that owns the port's registers. One is the acknowledge bit of a read of the input port register. The other is the stop condition that closes a transaction addressed to this device. On either bus clear, the snapshot is reloaded from the current pin levels, so every later change is detected again. Traffic addressed to other devices has no effect.

The bus slave supplies three single-cycle strobes in the block's clock domain: read-acknowledge, stop-detected, and a level that stays high for the whole of a transaction that matched this device's address.

Top module: `pinchg_irq`

## Requirements
- R1: After reset is released, the snapshot holds the pin levels present at release, and the request stays deasserted (`irq_oe_o`=0) until a pin changes.
- R2: A rising level on an input-mode pin (`dir_in_i` bit = 1) asserts the request exactly 3 clock edges after the pin changes: two synchronizer edges, then one register edge.
- R3: A falling level on an input-mode pin asserts the request with the same 3-edge latency.
- R4: When every input-mode pin is back at its snapshot level, the request deasserts 3 edges after the last pin returns, with no bus action.
- R5: A pin whose `dir_in_i` bit is 0 (output mode) never asserts the request, however it toggles.
- R6: `rd_ack_i` high together with `addr_match_i` high deasserts the request on the next edge and reloads the snapshot from the synchronized pins.
- R7: `rd_ack_i` or `stop_i` with `addr_match_i` low leaves both the request and the snapshot unchanged.
- R8: `stop_i` high together with `addr_match_i` high deasserts the request on the next edge and reloads the snapshot.
- R9: Changing a pin's `dir_in_i` bit from 0 to 1 asserts the request on the next edge if the pin's synchronized level differs from its snapshot bit.
- R10: After a bus clear, a new change on an input-mode pin asserts the request again.
- R11: A pin change that reaches the synchronizer output in the same cycle as a bus clear is absorbed into the snapshot and raises no request.
- R12: `irq_n_o` is low exactly when `irq_oe_o` is high. `irq_oe_o` is the pull-low enable; `irq_n_o` is released (1) otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | 8 | Raw port pin levels |
| dir_in_i | input | 8 | Direction mask, 1 = input mode |
| addr_match_i | input | 1 | The current bus transaction is addressed to this device |
| rd_ack_i | input | 1 | Acknowledge bit of an input-register read, single cycle |
| stop_i | input | 1 | Stop condition detected, single cycle |
| irq_oe_o | output | 1 | Pull-low enable of the request line |
| irq_n_o | output | 1 | Active-low request level |

## Verification
The hardest case to reach is a pin change that reaches the synchronizer output in the same cycle as a bus clear (R11). The bench lands it by changing the pins at a known falling edge and pulsing the matched stop exactly two edges later. Output-to-input direction flips (R9) are reached by first toggling pins while they are masked, then unmasking them with no further pin activity. A behavioural reference model, built from a queue of sampled pins, is compared on every cycle alongside the directed checks.

// File: rtl/pinchg_pkg.sv
package pinchg_pkg;
  typedef enum logic [1:0] {
    CLR_NONE = 2'd0,
    CLR_READ = 2'd1,
    CLR_STOP = 2'd2
  } clr_src_e;
endpackage

// File: rtl/pinchg_sync.sv
module pinchg_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[g] <= '0;
      end else if (g == 0) begin
        stage_q[g] <= d_i;
      end else begin
        stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pinchg_cmp.sv
module pinchg_cmp #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] live_i,
  input  logic [WIDTH-1:0] snap_i,
  input  logic [WIDTH-1:0] dir_in_i,
  output logic             any_o
);
  logic [WIDTH-1:0] diff;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign diff[g] = dir_in_i[g] & (live_i[g] ^ snap_i[g]);
  end

  assign any_o = |diff;
endmodule

// File: rtl/pinchg_ctrl.sv
module pinchg_ctrl
  import pinchg_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int INIT_CYCLES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] live_i,
  input  logic             any_i,
  input  logic             addr_match_i,
  input  logic             rd_ack_i,
  input  logic             stop_i,
  output logic [WIDTH-1:0] snap_o,
  output logic             irq_o,
  output logic             clr_o,
  output logic             init_done_o
);
  localparam int CW = $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] INIT_LOAD = CW'(INIT_CYCLES);

  clr_src_e         src;
  logic [WIDTH-1:0] snap_q;
  logic             irq_q;
  logic [CW-1:0]    cnt_q;

  always_comb begin
    src = CLR_NONE;
    if (addr_match_i && rd_ack_i)    src = CLR_READ;
    else if (addr_match_i && stop_i) src = CLR_STOP;
  end

  // snapshot tracks the pins until the synchronizer holds real data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      irq_q  <= 1'b0;
      cnt_q  <= INIT_LOAD;
    end else if (cnt_q != '0) begin
      snap_q <= live_i;
      irq_q  <= 1'b0;
      cnt_q  <= cnt_q - 1'b1;
    end else if (src != CLR_NONE) begin
      snap_q <= live_i;
      irq_q  <= 1'b0;
    end else begin
      irq_q  <= any_i;
    end
  end

  assign snap_o      = snap_q;
  assign irq_o       = irq_q;
  assign clr_o       = (src != CLR_NONE);
  assign init_done_o = (cnt_q == '0);
endmodule

// File: rtl/pinchg_irq.sv
module pinchg_irq #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pins_i,
  input  logic [WIDTH-1:0] dir_in_i,
  input  logic             addr_match_i,
  input  logic             rd_ack_i,
  input  logic             stop_i,
  output logic             irq_oe_o,
  output logic             irq_n_o
);
  localparam int INIT_CYCLES = SYNC_STAGES + 1;

  logic [WIDTH-1:0] live_w;
  logic [WIDTH-1:0] snap_w;
  logic             any_w;
  logic             irq_w;
  logic             clr_w;
  logic             init_done_w;

  pinchg_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_i),
    .q_o    (live_w)
  );

  pinchg_cmp #(.WIDTH(WIDTH)) u_cmp (
    .live_i   (live_w),
    .snap_i   (snap_w),
    .dir_in_i (dir_in_i),
    .any_o    (any_w)
  );

  pinchg_ctrl #(.WIDTH(WIDTH), .INIT_CYCLES(INIT_CYCLES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .live_i       (live_w),
    .any_i        (any_w),
    .addr_match_i (addr_match_i),
    .rd_ack_i     (rd_ack_i),
    .stop_i       (stop_i),
    .snap_o       (snap_w),
    .irq_o        (irq_w),
    .clr_o        (clr_w),
    .init_done_o  (init_done_w)
  );

  assign irq_oe_o = irq_w;
  assign irq_n_o  = ~irq_w;
endmodule

// File: rtl/pinchg_irq_chk.sv
module pinchg_irq_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] dir_in_i,
  input logic             addr_match_i,
  input logic             rd_ack_i,
  input logic             stop_i,
  input logic             irq_oe_o,
  input logic [WIDTH-1:0] snap_w,
  input logic             init_done_w
);
  a_r5_outputs_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_in_i == '0) |=> !irq_oe_o);

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_match_i && rd_ack_i) |=> !irq_oe_o);

  a_r8_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_match_i && stop_i) |=> !irq_oe_o);

  a_r7_snap_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done_w && !addr_match_i) |=> $stable(snap_w));
endmodule

bind pinchg_irq pinchg_irq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dir_in_i     (dir_in_i),
  .addr_match_i (addr_match_i),
  .rd_ack_i     (rd_ack_i),
  .stop_i       (stop_i),
  .irq_oe_o     (irq_oe_o),
  .snap_w       (snap_w),
  .init_done_w  (init_done_w)
);

// File: tb/pinchg_irq_test.sv
module pinchg_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = 8'hA5;
  logic [7:0] dir = 8'hFF;
  logic       match = 1'b0;
  logic       rack = 1'b0;
  logic       stp = 1'b0;
  logic       irq_oe;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference
  logic [7:0] hist[$];
  int         m_cnt = 3;
  logic [7:0] m_snap = 8'h00;
  logic       m_irq = 1'b0;

  always #2 clk = ~clk;

  pinchg_irq uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pins_i       (pins),
    .dir_in_i     (dir),
    .addr_match_i (match),
    .rd_ack_i     (rack),
    .stop_i       (stp),
    .irq_oe_o     (irq_oe),
    .irq_n_o      (irq_n)
  );

  always @(posedge clk) begin
    logic [7:0] s;
    if (!rst_n) begin
      hist.delete();
      m_cnt  = 3;
      m_snap = 8'h00;
      m_irq  = 1'b0;
    end else begin
      s = (hist.size() >= 2) ? hist[hist.size()-2] : 8'h00;
      if (m_cnt > 0) begin
        m_snap = s; m_irq = 1'b0; m_cnt--;
      end else if (match && (rack || stp)) begin
        m_snap = s; m_irq = 1'b0;
      end else begin
        m_irq = |((s ^ m_snap) & dir);
      end
      hist.push_back(pins);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq_oe !== m_irq) begin
        errors++;
        $display("FAIL R2 model: irq_oe=%0b expected %0b at %0t", irq_oe, m_irq, $time);
      end
      checks++;
      if (irq_n !== ~irq_oe) begin // R12
        errors++;
        $display("FAIL R12 open-drain pair: irq_n=%0b expected %0b", irq_n, ~irq_oe);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_irq(input logic exp, input string tag);
    checks++;
    if (irq_oe !== exp) begin
      errors++;
      $display("FAIL %s: irq_oe=%0b expected %0b", tag, irq_oe, exp);
    end
  endtask

  task automatic bus_pulse(input logic m, input logic r, input logic s);
    match = m; rack = r; stp = s;
    step(1);
    match = 1'b0; rack = 1'b0; stp = 1'b0;
  endtask

  task automatic report();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    report();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(6);
    expect_irq(1'b0, "R1 reset snapshot");
    pins = 8'hA7;                 // bit1 rises
    step(2); expect_irq(1'b0, "R2 latency not yet");
    step(1); expect_irq(1'b1, "R2 rising edge");
    pins = 8'hA5;
    step(3); expect_irq(1'b0, "R4 revert clears");
    pins = 8'hA4;                 // bit0 falls
    step(3); expect_irq(1'b1, "R3 falling edge");
    bus_pulse(1'b1, 1'b1, 1'b0);
    expect_irq(1'b0, "R6 read ack clears");
    step(3); expect_irq(1'b0, "R6 snapshot reloaded");
    pins = 8'hA5;
    step(3); expect_irq(1'b1, "R10 re-detect after clear");
    bus_pulse(1'b0, 1'b1, 1'b0);
    expect_irq(1'b1, "R7 unmatched read");
    bus_pulse(1'b0, 1'b0, 1'b1);
    expect_irq(1'b1, "R7 unmatched stop");
    bus_pulse(1'b1, 1'b0, 1'b1);
    expect_irq(1'b0, "R8 matched stop clears");
    dir = 8'h0F;
    pins = 8'h55;
    step(4); expect_irq(1'b0, "R5 output pins masked");
    pins = 8'hA5; step(3);
    pins = 8'h55; step(4); expect_irq(1'b0, "R5 output toggles masked");
    dir = 8'hFF;
    step(1); expect_irq(1'b1, "R9 output to input mismatch");
    bus_pulse(1'b1, 1'b0, 1'b1);
    expect_irq(1'b0, "R8 stop clears");
    pins = 8'h54;
    step(2);
    bus_pulse(1'b1, 1'b0, 1'b1);
    expect_irq(1'b0, "R11 change at clear");
    step(3); expect_irq(1'b0, "R11 change absorbed");
    dir = 8'h00; step(1);
    dir = 8'hFF; step(1);
    expect_irq(1'b0, "R9 flip with matching level");
    step(4);
    report();
  end
endmodule